// File: doc/BRIEF.md
# Glitch-Free Gated Clock Output Bank

This block distributes one internal clock to six gated clock outputs and one feedback clock output. Each of the six channel outputs has its own enable, and a common run input can stop all six together. The feedback output ignores both: once reset has cleared, it always follows the internal clock. When a channel is stopped it parks LOW. Every enable change is carried across a two-stage synchronizer that advances on the falling edge of the internal clock, so a gate can only open or close while the clock is LOW. Because of this, no output ever produces a pulse shorter than a full high phase.

A float request sets an active-low output-enable bit for each of the seven pins. Pad logic uses these bits to put the pins into high impedance so that a tester can back-drive them. The float request has no effect on the clock values themselves. After an asynchronous reset every gate is closed, and the feedback output also waits for its own constant enable to pass the synchronizer.

Top module: `cgo_out_bank`

## Requirements
- R1: While a channel is enabled and the run input is high, its output `clk_out[i]` follows the internal clock during each high phase.
- R2: A channel whose enable `chan_en[i]` is 0 keeps its output LOW for whole clock cycles. The other channels are not affected.
- R3: No output is high while the internal clock is low. Every output pulse rises on a rising edge of the internal clock and lasts exactly one full high phase.
- R4: When `all_run` is 0, all six channel outputs are held LOW, whatever their individual enables are.
- R5: `clk_fb` ignores `all_run` and `chan_en`. It follows the internal clock in every high phase that starts after the second falling edge after reset release.
- R6: When `float_req` is 1, all seven bits of `pin_oe_n` are 1 (high impedance). When it is 0, all seven bits are 0. Bit 6 belongs to the feedback pin and bits 5..0 to `clk_out[5..0]`. The float request does not change the clock values.
- R7: Enable and run values are sampled on falling edge k. They decide the gate for the high phase that follows falling edge k+1, which begins at the second rising edge after the sampling edge.
- R8: `rst_n` low clears all gates asynchronously. All outputs, `clk_fb` included, stay LOW until two falling edges have passed after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Internal clock to distribute |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 6 | Per-channel enable, 1 = run |
| all_run | input | 1 | Common run control, 0 stops all six channels |
| float_req | input | 1 | Test float request, 1 = pins high impedance |
| clk_out | output | 6 | Gated channel clocks |
| clk_fb | output | 1 | Feedback clock, free of the common control |
| pin_oe_n | output | 7 | Active-low pad output enables, bit 6 = feedback |

## Verification
An enable or run change sampled on falling edge k first shows in the high phase that opens one full cycle later. The bench therefore keeps its own two-deep history of the sampled inputs, shifted on each falling edge. It compares every pin 2 ns into each high phase against the older history entry, and checks 2 ns into each low phase that all pins are LOW. The output-enable bits have no register delay, so they are checked 1 ns after each input change. A monitor per pin measures every pulse from rising to falling edge and requires exactly one half period.

// File: rtl/cgo_pkg.sv
`timescale 1ns/1ps
package cgo_pkg;
    localparam int unsigned CGO_CHANNELS    = 6;
    localparam int unsigned CGO_SYNC_STAGES = 2;

    // Effective request of one channel: its own enable qualified by the common run.
    function automatic logic cgo_merge(input logic ind_en, input logic grp_run);
        return ind_en & grp_run;
    endfunction
endpackage

// File: rtl/cgo_enable_sync.sv
`timescale 1ns/1ps
module cgo_enable_sync #(
    parameter int unsigned WIDTH  = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_core,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    // Falling-edge stages: the last stage only moves while the clock is low.
    always_ff @(negedge clk_core or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.pipe[STAGES-1];
endmodule

// File: rtl/cgo_gate_cell.sv
`timescale 1ns/1ps
module cgo_gate_cell (
    input  logic clk_core,
    input  logic gate_on,
    output logic clk_gated
);
    // gate_on changes only during the low phase, so the AND cannot chop a pulse.
    assign clk_gated = clk_core & gate_on;
endmodule

// File: rtl/cgo_pad_ctrl.sv
`timescale 1ns/1ps
module cgo_pad_ctrl #(
    parameter int unsigned PINS = 7
) (
    input  logic            float_req,
    output logic [PINS-1:0] oe_n
);
    always_comb begin
        oe_n = {PINS{float_req}};
    end
endmodule

// File: rtl/cgo_out_bank.sv
`timescale 1ns/1ps
module cgo_out_bank
    import cgo_pkg::*;
#(
    parameter int unsigned N_CH     = CGO_CHANNELS,
    parameter int unsigned N_STAGES = CGO_SYNC_STAGES
) (
    input  logic            clk_core,
    input  logic            rst_n,
    input  logic [N_CH-1:0] chan_en,
    input  logic            all_run,
    input  logic            float_req,
    output logic [N_CH-1:0] clk_out,
    output logic            clk_fb,
    output logic [N_CH:0]   pin_oe_n
);
    localparam int unsigned N_PIN  = N_CH + 1;
    localparam int unsigned FB_IDX = N_CH;

    logic [N_PIN-1:0] req_w;
    logic [N_PIN-1:0] gate_w;
    logic [N_PIN-1:0] pin_clk_w;

    for (genvar i = 0; i < N_CH; i++) begin : g_req
        assign req_w[i] = cgo_merge(chan_en[i], all_run);
    end
    // The feedback pin requests a constant run, so it only waits out reset.
    assign req_w[FB_IDX] = 1'b1;

    cgo_enable_sync #(
        .WIDTH  (N_PIN),
        .STAGES (N_STAGES)
    ) u_sync (
        .clk_core (clk_core),
        .rst_n    (rst_n),
        .async_in (req_w),
        .sync_out (gate_w)
    );

    for (genvar p = 0; p < N_PIN; p++) begin : g_gate
        cgo_gate_cell u_cell (
            .clk_core  (clk_core),
            .gate_on   (gate_w[p]),
            .clk_gated (pin_clk_w[p])
        );
    end

    cgo_pad_ctrl #(
        .PINS (N_PIN)
    ) u_pad (
        .float_req (float_req),
        .oe_n      (pin_oe_n)
    );

    assign clk_out = pin_clk_w[N_CH-1:0];
    assign clk_fb  = pin_clk_w[FB_IDX];
endmodule

// File: rtl/cgo_out_bank_chk.sv
`timescale 1ns/1ps
module cgo_out_bank_chk #(
    parameter int unsigned N_CH = 6
) (
    input logic            clk_core,
    input logic            rst_n,
    input logic [N_CH-1:0] chan_en,
    input logic            all_run,
    input logic            float_req,
    input logic [N_CH-1:0] clk_out,
    input logic            clk_fb,
    input logic [N_CH:0]   pin_oe_n
);
    // Falling edges seen since reset release, saturating.
    logic [1:0] rel_cnt;
    always_ff @(negedge clk_core or negedge rst_n) begin
        if (!rst_n) begin
            rel_cnt <= '0;
        end else if (rel_cnt != 2'd3) begin
            rel_cnt <= rel_cnt + 2'd1;
        end
    end

    // R3: just before every rising edge the clock was low, so every pin must be low.
    a_r3_low_before_rise: assert property (@(posedge clk_core) disable iff (!rst_n)
        (clk_out == '0) && !clk_fb);

    // R7 with R1: the high phase ending at this falling edge reflects inputs from two edges back.
    a_r7_gate_latency: assert property (@(negedge clk_core) disable iff (!rst_n)
        (rel_cnt >= 2'd2) |-> (clk_out == ($past(chan_en, 2) & {N_CH{$past(all_run, 2)}})));

    // R4: a stop two edges back silences every channel.
    a_r4_common_stop: assert property (@(negedge clk_core) disable iff (!rst_n)
        ((rel_cnt >= 2'd2) && !$past(all_run, 2)) |-> (clk_out == '0));

    // R5: the feedback pin runs once the synchronizer has filled.
    a_r5_fb_runs: assert property (@(negedge clk_core) disable iff (!rst_n)
        (rel_cnt >= 2'd2) |-> clk_fb);

    // R8: no pin pulses in the first high phase after release.
    a_r8_quiet_start: assert property (@(negedge clk_core) disable iff (!rst_n)
        (rel_cnt < 2'd2) |-> ((clk_out == '0) && !clk_fb));

    // R6: float request drives all pad enables.
    a_r6_float_all: assert property (@(posedge clk_core) disable iff (!rst_n)
        float_req |-> (pin_oe_n == '1));
    a_r6_drive_all: assert property (@(posedge clk_core) disable iff (!rst_n)
        !float_req |-> (pin_oe_n == '0));
endmodule

bind cgo_out_bank cgo_out_bank_chk #(.N_CH(N_CH)) u_chk (
    .clk_core  (clk_core),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .all_run   (all_run),
    .float_req (float_req),
    .clk_out   (clk_out),
    .clk_fb    (clk_fb),
    .pin_oe_n  (pin_oe_n)
);

// File: tb/tb_cgo_out_bank.sv
`timescale 1ns/1ps
module tb_cgo_out_bank;
    localparam int NC = 6;
    localparam int NP = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NC-1:0] chan_en;
    logic          all_run;
    logic          float_req;
    logic [NC-1:0] clk_out;
    logic          clk_fb;
    logic [NP-1:0] pin_oe_n;
    wire  [NP-1:0] pins = {clk_fb, clk_out};

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Input history sampled on falling edges (index 1 is the older entry).
    logic [NC-1:0] hc0, hc1;
    logic          hr0, hr1, hf0, hf1;
    int            nrel;

    always #4 clk = ~clk;   // 125 MHz

    cgo_out_bank dut (
        .clk_core  (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .all_run   (all_run),
        .float_req (float_req),
        .clk_out   (clk_out),
        .clk_fb    (clk_fb),
        .pin_oe_n  (pin_oe_n)
    );

    function automatic logic [NP-1:0] exp_high();
        if (!rst_n) return '0;
        return {hf1, hc1 & {NC{hr1}}};
    endfunction

    function automatic string pin_tag(int g);
        if (!rst_n || nrel < 2) return "R8";
        if (g == NC)            return "R5";
        if (!hc1[g])            return "R2";
        if (!hr1)               return "R4";
        return "R1 R7";
    endfunction

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc0 <= '0; hc1 <= '0; hr0 <= 1'b0; hr1 <= 1'b0;
            hf0 <= 1'b0; hf1 <= 1'b0; nrel <= 0;
        end else begin
            hc1 <= hc0; hc0 <= chan_en;
            hr1 <= hr0; hr0 <= all_run;
            hf1 <= hf0; hf0 <= 1'b1;
            if (nrel < 3) nrel <= nrel + 1;
        end
    end

    // High-phase check of every pin plus the pad enables.
    always @(posedge clk) begin
        #2;
        begin
            logic [NP-1:0] e;
            e = exp_high();
            for (int g = 0; g < NP; g++) begin
                checks++;
                if (pins[g] !== e[g]) begin
                    errors++;
                    $display("FAIL %s pin %0d high phase actual=%b expected=%b", pin_tag(g), g, pins[g], e[g]);
                end
            end
            checks++;
            if (pin_oe_n !== {NP{float_req}}) begin
                errors++;
                $display("FAIL R6 pad enables actual=%b expected=%b", pin_oe_n, {NP{float_req}});
            end
        end
    end

    // Low-phase check: R3 no pin high while the clock is low.
    always @(negedge clk) begin
        #2;
        checks++;
        if (pins !== '0) begin
            errors++;
            $display("FAIL R3 low phase actual=%b expected=%b", pins, {NP{1'b0}});
        end
    end

    // R3 pulse monitor: each pulse is one full half period, aligned to the clock.
    for (genvar g = 0; g < NP; g++) begin : g_mon
        time t_up;
        bit  seen = 1'b0;
        always @(posedge pins[g]) begin
            t_up = $time;
            seen = 1'b1;
            checks++;
            if (clk !== 1'b1) begin
                errors++;
                $display("FAIL R3 pin %0d rose off clock edge actual=%b expected=1", g, clk);
            end
        end
        always @(negedge pins[g]) begin
            if (seen && rst_n) begin
                checks++;
                if (($time - t_up) != 4) begin
                    errors++;
                    $display("FAIL R3 pin %0d pulse width actual=%0t expected=4", g, $time - t_up);
                end
            end
        end
    end

    task automatic step(input logic [NC-1:0] en, input logic run, input logic fl);
        @(posedge clk);
        #1;
        chan_en = en; all_run = run; float_req = fl;
    endtask

    task automatic pulse_reset();
        @(negedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(64'd8 * 64'd200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd51973));
        rst_n = 1'b0; chan_en = '1; all_run = 1'b1; float_req = 1'b0;
        repeat (3) @(posedge clk);              // R8 reset state
        @(negedge clk); #1 rst_n = 1'b1;
        repeat (12) step('1, 1'b1, 1'b0);       // R1 all running
        repeat (8)  step(6'h3E, 1'b1, 1'b0);    // R2 one channel off
        repeat (8)  step(6'h00, 1'b1, 1'b0);    // R2 all off, R5 fb runs
        repeat (8)  step('1, 1'b0, 1'b0);       // R4 common stop
        repeat (4)  step('1, 1'b1, 1'b0);
        for (int k = 0; k < 10; k++)            // R7 single-cycle toggles
            step((k % 2) ? 6'h15 : 6'h2A, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++)             // R4 stop toggling every cycle
            step(6'h3F, k[0], 1'b0);
        repeat (6)  step(6'h0F, 1'b1, 1'b1);    // R6 float
        repeat (4)  step(6'h0F, 1'b1, 1'b0);
        pulse_reset();                          // R8 mid-run reset
        repeat (6)  step('1, 1'b1, 1'b0);
        for (int k = 0; k < 500; k++) begin
            logic [NC-1:0] en;
            en = NC'($urandom);
            step(en, ($urandom % 5) != 0, ($urandom % 8) == 0);
            if (k == 250) pulse_reset();
        end
        repeat (4) step('1, 1'b1, 1'b0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule